// File: doc/BRIEF.md
# Port-Mapped System Control Register Bank

This block is a bank of byte-wide control and identification registers that sits on an ISA-style I/O port bus. A single-cycle read or write strobe, together with an I/O address, selects one of ten byte ports. Each port has its own access rule: some ports are read/write with masked storage, some are fixed read-only values, and some are write-only sinks whose data is discarded. Flags inside a byte are numbered from the most significant end, so flag n has the value `1 << (7 - n)`. As a result, the control flags land in the low-order bits.

Three ports drive state out of the block. The soft-reset port drives a soft-reset line. The map-type port drives a line that selects the non-contiguous I/O map; this line is asserted out of reset. A write to the soft-reset port that requests little-endian mode does not change byte order. It raises a one-cycle unsupported-mode error pulse instead.

The block also claims a 4-byte error-status window in memory space. Only aligned word reads are accepted there, and they return zero. Any write to the window produces a one-cycle invalid-access pulse.

Top module: `sysctl_port_bank`

## Requirements
- R1: `io_hit_o` is high only while a read or write strobe targets one of the byte ports 0x092, 0x808, 0x80C, 0x810, 0x812, 0x814, 0x818, 0x81C, 0x850 or 0x852.
- R2: After reset, the soft-reset byte reads 0x00, the system-control byte reads 0x00 and the map-type byte reads 0x01. In the same state `soft_reset_o` is 0, `noncontig_map_o` is 1, and both pulse outputs are 0.
- R3: A write to 0x092 stores `wdata & 0x01`. From the next cycle, `soft_reset_o` equals bit 0 of the stored byte. A read of 0x092 returns the stored byte.
- R4: A write to 0x092 with bit value 0x02 set makes `mode_err_o` high for exactly the one cycle that follows the write edge. Without that bit set, `mode_err_o` stays low.
- R5: A write to 0x81C stores `wdata & 0xF0`, and a read of 0x81C returns the stored byte.
- R6: A write to 0x850 stores `wdata & 0x01`. From the next cycle, `noncontig_map_o` equals bit 0 of the stored byte. A read of 0x850 returns the stored byte.
- R7: A read of 0x80C returns parameter `EQUIP_VAL`, and a read of 0x852 returns parameter `BOARD_ID`. Both parameters default to 0x00.
- R8: A read of 0x818 always returns 0x00.
- R9: Writes to 0x808, 0x810, 0x812 and 0x814 change no stored byte and no output. A read of any of these four ports returns 0xFF.
- R10: A read of an address outside the port list returns 0xFF, and `io_hit_o` stays low for it.
- R11: A memory read with `mem_size_i` = 2 (word) at the aligned base 0xBFFFEFF0 asserts `mem_hit_o` and returns zero data. Any other access size, or any misaligned address, leaves `mem_hit_o` low.
- R12: A memory write of any size to any byte of 0xBFFFEFF0..0xBFFFEFF3 makes `bad_access_o` high for exactly the one cycle after the write edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| io_rd_i | input | 1 | I/O read strobe |
| io_wr_i | input | 1 | I/O write strobe |
| io_addr_i | input | 16 | I/O port address |
| io_wdata_i | input | 8 | I/O write data |
| io_rdata_o | output | 8 | I/O read data, combinational from the address |
| io_hit_o | output | 1 | A strobe targets a decoded port |
| mem_rd_i | input | 1 | Memory read strobe |
| mem_wr_i | input | 1 | Memory write strobe |
| mem_addr_i | input | 32 | Memory byte address |
| mem_size_i | input | 2 | Access size: 0 byte, 1 half, 2 word |
| mem_rdata_o | output | 32 | Error-window read data |
| mem_hit_o | output | 1 | Word read accepted by the window |
| soft_reset_o | output | 1 | Soft-reset line |
| noncontig_map_o | output | 1 | Non-contiguous I/O map select |
| mode_err_o | output | 1 | Unsupported byte-order request pulse |
| bad_access_o | output | 1 | Invalid window write pulse |

## Verification
Each stored byte can be read back through its own port on the very next strobe. Two of the bytes also drive a line, so a bad mask or a lost write shows on `soft_reset_o` or `noncontig_map_o` in the cycle after the write. A write-only port that leaks into a neighbour's storage only shows when the affected readable port is read again. For that reason, each such write is followed at once by reads of every stored byte. A pulse that stretches or fires on the wrong port is visible in the single cycle after the offending write, and the bench samples exactly that cycle.

// File: rtl/sysctl_pkg.sv
`timescale 1ns/1ps
package sysctl_pkg;
  localparam int NPORT = 10;

  typedef enum int {
    P_SRST = 0, P_LIGHT = 1, P_EQUIP = 2, P_PW1 = 3, P_PW2 = 4,
    P_L2INV = 5, P_KEY = 6, P_SYSCTL = 7, P_MAPT = 8, P_BOARD = 9
  } port_e;

  localparam logic [NPORT-1:0][15:0] PORT_ADDR = {
    16'h0852, 16'h0850, 16'h081C, 16'h0818, 16'h0814,
    16'h0812, 16'h0810, 16'h080C, 16'h0808, 16'h0092
  };

  // MSB-first flag numbering
  function automatic logic [7:0] flag(input int n);
    return 8'(1) << (7 - n);
  endfunction

  localparam logic [7:0] SRST_MASK   = flag(7);
  localparam logic [7:0] LE_REQ      = flag(6);
  localparam logic [7:0] SYSCTL_MASK = flag(0) | flag(1) | flag(2) | flag(3);
  localparam logic [7:0] MAPT_MASK   = flag(7);
  localparam logic [7:0] FLOAT_VAL   = 8'hFF;
  localparam logic [1:0] SZ_WORD     = 2'd2;
endpackage

// File: rtl/sysctl_io_decode.sv
`timescale 1ns/1ps
module sysctl_io_decode
  import sysctl_pkg::*;
#(
  parameter int IO_AW = 16
) (
  input  logic [IO_AW-1:0] addr_i,
  output logic [NPORT-1:0] sel_o
);
  for (genvar i = 0; i < NPORT; i++) begin : g_port
    assign sel_o[i] = (addr_i == IO_AW'(PORT_ADDR[i]));
  end
endmodule

// File: rtl/sysctl_io_regs.sv
`timescale 1ns/1ps
module sysctl_io_regs
  import sysctl_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [NPORT-1:0] sel_i,
  input  logic [7:0]       wdata_i,
  output logic [7:0]       srst_q_o,
  output logic [7:0]       sysctl_q_o,
  output logic [7:0]       mapt_q_o,
  output logic             mode_err_o
);
  logic wr_srst, wr_sysctl, wr_mapt;
  assign wr_srst   = wr_i & sel_i[P_SRST];
  assign wr_sysctl = wr_i & sel_i[P_SYSCTL];
  assign wr_mapt   = wr_i & sel_i[P_MAPT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      srst_q_o   <= 8'h00;
      sysctl_q_o <= 8'h00;
      mapt_q_o   <= MAPT_MASK;
      mode_err_o <= 1'b0;
    end else begin
      if (wr_srst)   srst_q_o   <= wdata_i & SRST_MASK;
      if (wr_sysctl) sysctl_q_o <= wdata_i & SYSCTL_MASK;
      if (wr_mapt)   mapt_q_o   <= wdata_i & MAPT_MASK;
      mode_err_o <= wr_srst & |(wdata_i & LE_REQ);
    end
  end
endmodule

// File: rtl/sysctl_err_window.sv
`timescale 1ns/1ps
module sysctl_err_window
  import sysctl_pkg::*;
#(
  parameter int          MEM_AW   = 32,
  parameter logic [31:0] WIN_BASE = 32'hBFFF_EFF0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic [MEM_AW-1:0] addr_i,
  input  logic [1:0]        size_i,
  output logic              hit_o,
  output logic [31:0]       rdata_o,
  output logic              bad_o
);
  localparam logic [MEM_AW-3:0] BASE_W = WIN_BASE[MEM_AW-1:2];

  logic in_win;
  assign in_win  = (addr_i[MEM_AW-1:2] == BASE_W);
  assign hit_o   = rd_i & in_win & (addr_i[1:0] == 2'b00) & (size_i == SZ_WORD);
  assign rdata_o = 32'h0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) bad_o <= 1'b0;
    else         bad_o <= wr_i & in_win;
  end
endmodule

// File: rtl/sysctl_port_bank.sv
`timescale 1ns/1ps
module sysctl_port_bank
  import sysctl_pkg::*;
#(
  parameter int          IO_AW     = 16,
  parameter int          MEM_AW    = 32,
  parameter logic [7:0]  EQUIP_VAL = 8'h00,
  parameter logic [7:0]  BOARD_ID  = 8'h00,
  parameter logic [31:0] WIN_BASE  = 32'hBFFF_EFF0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              io_rd_i,
  input  logic              io_wr_i,
  input  logic [IO_AW-1:0]  io_addr_i,
  input  logic [7:0]        io_wdata_i,
  output logic [7:0]        io_rdata_o,
  output logic              io_hit_o,
  input  logic              mem_rd_i,
  input  logic              mem_wr_i,
  input  logic [MEM_AW-1:0] mem_addr_i,
  input  logic [1:0]        mem_size_i,
  output logic [31:0]       mem_rdata_o,
  output logic              mem_hit_o,
  output logic              soft_reset_o,
  output logic              noncontig_map_o,
  output logic              mode_err_o,
  output logic              bad_access_o
);
  logic [NPORT-1:0] sel;
  logic [7:0]       srst_q, sysctl_q, mapt_q;

  sysctl_io_decode #(.IO_AW(IO_AW)) u_dec (
    .addr_i (io_addr_i),
    .sel_o  (sel)
  );

  sysctl_io_regs u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_i       (io_wr_i),
    .sel_i      (sel),
    .wdata_i    (io_wdata_i),
    .srst_q_o   (srst_q),
    .sysctl_q_o (sysctl_q),
    .mapt_q_o   (mapt_q),
    .mode_err_o (mode_err_o)
  );

  sysctl_err_window #(.MEM_AW(MEM_AW), .WIN_BASE(WIN_BASE)) u_win (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .rd_i    (mem_rd_i),
    .wr_i    (mem_wr_i),
    .addr_i  (mem_addr_i),
    .size_i  (mem_size_i),
    .hit_o   (mem_hit_o),
    .rdata_o (mem_rdata_o),
    .bad_o   (bad_access_o)
  );

  assign io_hit_o        = (io_rd_i | io_wr_i) & |sel;
  assign soft_reset_o    = |(srst_q & SRST_MASK);
  assign noncontig_map_o = |(mapt_q & MAPT_MASK);

  // write-only and unmapped ports float high
  always_comb begin
    io_rdata_o = FLOAT_VAL;
    unique case (1'b1)
      sel[P_SRST]:   io_rdata_o = srst_q;
      sel[P_EQUIP]:  io_rdata_o = EQUIP_VAL;
      sel[P_KEY]:    io_rdata_o = 8'h00;
      sel[P_SYSCTL]: io_rdata_o = sysctl_q;
      sel[P_MAPT]:   io_rdata_o = mapt_q;
      sel[P_BOARD]:  io_rdata_o = BOARD_ID;
      default:       io_rdata_o = FLOAT_VAL;
    endcase
  end
endmodule

// File: rtl/sysctl_port_bank_chk.sv
`timescale 1ns/1ps
module sysctl_port_bank_chk #(
  parameter int IO_AW  = 16,
  parameter int MEM_AW = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              io_rd_i,
  input logic              io_wr_i,
  input logic [IO_AW-1:0]  io_addr_i,
  input logic [7:0]        io_wdata_i,
  input logic [7:0]        io_rdata_o,
  input logic              io_hit_o,
  input logic              mem_rd_i,
  input logic              mem_wr_i,
  input logic [MEM_AW-1:0] mem_addr_i,
  input logic [1:0]        mem_size_i,
  input logic [31:0]       mem_rdata_o,
  input logic              mem_hit_o,
  input logic              soft_reset_o,
  input logic              noncontig_map_o,
  input logic              mode_err_o,
  input logic              bad_access_o
);
  logic listed, a_srst, a_mapt, a_sys, a_key, in_win;
  assign listed = io_addr_i inside {16'h092, 16'h808, 16'h80C, 16'h810, 16'h812,
                                    16'h814, 16'h818, 16'h81C, 16'h850, 16'h852};
  assign a_srst = (io_addr_i == 16'h092);
  assign a_mapt = (io_addr_i == 16'h850);
  assign a_sys  = (io_addr_i == 16'h81C);
  assign a_key  = (io_addr_i == 16'h818);
  assign in_win = (mem_addr_i[MEM_AW-1:2] == 30'h2FFF_FBFC);

  AST_HIT_LISTED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    io_hit_o |-> listed); // R1
  AST_SRST_FOLLOWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (io_wr_i && a_srst) |=> (soft_reset_o == $past(io_wdata_i[0]))); // R3
  AST_MODE_ERR_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_err_o |-> $past(io_wr_i && a_srst && io_wdata_i[1])); // R4
  AST_SYSCTL_LOW_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (io_rd_i && a_sys) |-> (io_rdata_o[3:0] == 4'h0)); // R5
  AST_MAP_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(io_wr_i && a_mapt) |=> $stable(noncontig_map_o)); // R6
  AST_KEY_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (io_rd_i && a_key) |-> (io_rdata_o == 8'h00)); // R8
  AST_WIN_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_hit_o |-> (mem_rdata_o == 32'h0 && mem_size_i == 2'd2)); // R11
  AST_BAD_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bad_access_o |-> $past(mem_wr_i && in_win)); // R12
  AST_BAD_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bad_access_o && !$past(mem_wr_i && in_win, 2)) |=> !bad_access_o); // R12
endmodule

bind sysctl_port_bank sysctl_port_bank_chk #(.IO_AW(IO_AW), .MEM_AW(MEM_AW)) u_chk (.*);

// File: tb/sysctl_port_bank_bench.sv
`timescale 1ns/1ps
module sysctl_port_bank_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic io_rd = 0, io_wr = 0, mem_rd = 0, mem_wr = 0;
  logic [15:0] io_addr = 0;
  logic [7:0]  io_wdata = 0, io_rdata;
  logic        io_hit, mem_hit, srst_o, map_o, merr, bad;
  logic [31:0] mem_addr = 0, mem_rdata;
  logic [1:0]  mem_size = 0;
  int total = 0, nbad = 0;
  bit done = 0;
  logic [7:0] m_srst, m_sys, m_map;

  always #2.5 clk = ~clk;

  sysctl_port_bank u_sysctl_port_bank (
    .clk_i(clk), .rst_ni(rst_n), .io_rd_i(io_rd), .io_wr_i(io_wr),
    .io_addr_i(io_addr), .io_wdata_i(io_wdata), .io_rdata_o(io_rdata),
    .io_hit_o(io_hit), .mem_rd_i(mem_rd), .mem_wr_i(mem_wr),
    .mem_addr_i(mem_addr), .mem_size_i(mem_size), .mem_rdata_o(mem_rdata),
    .mem_hit_o(mem_hit), .soft_reset_o(srst_o), .noncontig_map_o(map_o),
    .mode_err_o(merr), .bad_access_o(bad));

  localparam logic [15:0] LIST [10] = '{16'h092, 16'h808, 16'h80C, 16'h810,
    16'h812, 16'h814, 16'h818, 16'h81C, 16'h850, 16'h852};

  function automatic bit listed(input logic [15:0] a);
    foreach (LIST[i]) if (LIST[i] == a) return 1'b1;
    return 1'b0;
  endfunction

  function automatic logic [7:0] exp_rd(input logic [15:0] a);
    case (a)
      16'h092: return m_srst;
      16'h80C: return 8'h00;
      16'h818: return 8'h00;
      16'h81C: return m_sys;
      16'h850: return m_map;
      16'h852: return 8'h00;
      default: return 8'hFF;
    endcase
  endfunction

  function automatic string tag_of(input logic [15:0] a);
    case (a)
      16'h092: return "R3";
      16'h80C, 16'h852: return "R7";
      16'h818: return "R8";
      16'h81C: return "R5";
      16'h850: return "R6";
      16'h808, 16'h810, 16'h812, 16'h814: return "R9";
      default: return "R10";
    endcase
  endfunction

  function automatic bit win_word(input logic [31:0] a, input logic [1:0] s);
    return a == 32'hBFFF_EFF0 && s == 2'd2;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic io_read(input logic [15:0] a);
    @(negedge clk);
    io_rd = 1; io_addr = a;
    #1;
    chk(tag_of(a), io_rdata, exp_rd(a));
    chk(listed(a) ? "R1" : "R10", io_hit, listed(a));
    @(negedge clk);
    io_rd = 0;
  endtask

  task automatic io_write(input logic [15:0] a, input logic [7:0] d);
    bit e_err;
    @(negedge clk);
    io_wr = 1; io_addr = a; io_wdata = d;
    #1 chk("R1", io_hit, listed(a));
    e_err = (a == 16'h092) && d[1];
    if (a == 16'h092) m_srst = d & 8'h01;
    if (a == 16'h81C) m_sys  = d & 8'hF0;
    if (a == 16'h850) m_map  = d & 8'h01;
    @(negedge clk);
    io_wr = 0;
    #1;
    chk("R4", merr, e_err);
    chk("R3", srst_o, m_srst[0]);
    chk("R6", map_o, m_map[0]);
    @(negedge clk);
    chk("R4", merr, 1'b0);
  endtask

  task automatic mem_op(input bit wr, input logic [31:0] a, input logic [1:0] s);
    bit inw;
    inw = (a[31:2] == 30'h2FFF_FBFC);
    @(negedge clk);
    mem_rd = !wr; mem_wr = wr; mem_addr = a; mem_size = s;
    #1;
    if (!wr) begin
      chk("R11", mem_hit, win_word(a, s));
      if (mem_hit) chk("R11", mem_rdata, 32'h0);
    end
    @(negedge clk);
    mem_rd = 0; mem_wr = 0;
    #1 chk("R12", bad, wr && inw);
    @(negedge clk);
    chk("R12", bad, 1'b0);
  endtask

  task automatic read_all();
    io_read(16'h092); io_read(16'h81C); io_read(16'h850);
  endtask

  initial begin
    #1000000;
    if (!done) begin
      nbad++; total++;
      $display("FAIL watchdog act=hung exp=finish");
      $display("test done: total=%0d bad=%0d", total, nbad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    m_srst = 0; m_sys = 0; m_map = 8'h01;
    repeat (3) @(negedge clk);
    // R2 reset state, while in reset and after release
    chk("R2", map_o, 1'b1); chk("R2", srst_o, 1'b0);
    chk("R2", merr, 1'b0); chk("R2", bad, 1'b0);
    rst_n = 1;
    read_all();
    io_read(16'h80C); io_read(16'h852); io_read(16'h818);
    // R3 R4 directed
    io_write(16'h092, 8'hFF); io_read(16'h092);
    io_write(16'h092, 8'h01);
    io_write(16'h092, 8'h00); io_read(16'h092);
    // R5 R6
    io_write(16'h81C, 8'hFF); io_read(16'h81C);
    io_write(16'h81C, 8'h5A); io_read(16'h81C);
    io_write(16'h850, 8'hFE); io_read(16'h850);
    io_write(16'h850, 8'h81); io_read(16'h850);
    // R9 write-only sinks, then all stored bytes
    io_write(16'h092, 8'h01); io_write(16'h81C, 8'hA0);
    foreach (LIST[i]) if (LIST[i] inside {16'h808, 16'h810, 16'h812, 16'h814}) begin
      io_write(LIST[i], 8'hFF); read_all(); io_read(LIST[i]);
      io_write(LIST[i], 8'h00); read_all();
    end
    // R10 unmapped
    io_read(16'h093); io_read(16'h080C ^ 16'h1000); io_read(16'hFFFF);
    io_write(16'h851, 8'hFF); read_all();
    // R11 R12 window
    mem_op(0, 32'hBFFF_EFF0, 2'd2); mem_op(0, 32'hBFFF_EFF0, 2'd0);
    mem_op(0, 32'hBFFF_EFF2, 2'd1); mem_op(0, 32'hBFFF_EFF4, 2'd2);
    mem_op(1, 32'hBFFF_EFF0, 2'd2); mem_op(1, 32'hBFFF_EFF3, 2'd0);
    mem_op(1, 32'hBFFF_EFEC, 2'd2);
    // random mix
    for (int n = 0; n < 400; n++) begin
      logic [15:0] a;
      int k;
      k = int'($urandom % 10);
      a = ($urandom % 5 == 0) ? 16'($urandom % 16'h0900) : LIST[k];
      case ($urandom % 4)
        0, 1: io_read(a);
        2: io_write(a, 8'($urandom));
        default: mem_op(1'($urandom), 32'hBFFF_EFEC + ($urandom % 12), 2'($urandom % 3));
      endcase
    end
    read_all();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, nbad);
    $finish;
  end
endmodule